// File: doc/BRIEF.md
# In-Order Completion File with Shadow Registers

This block keeps a program-order log of every instruction that the dispatcher hands to a reservation station. It takes up to two new entries per cycle. It also takes one result report per cycle from the result bus, which carries a station tag, a data word and a fault flag. Entries leave the log strictly from the oldest end, at up to two per cycle. Each leaving entry copies its result into a private shadow copy of the architectural registers. The program counter of the youngest retired entry is published so that store stations can hold back until their predecessor has finished.

When the oldest unretired entry carries a fault, normal operation ends. An arithmetic fault still retires its own result. A memory fault is discarded, so the published counter stays on the last good instruction. The block then streams the whole shadow register set onto a side-band write port, one register per cycle, so that the register file drops its speculative values and rename tags. After that it raises a sticky clean flag and waits for reset.

The dispatch side is a valid/ready stream. Slot 0 is the older instruction and slot 1 the younger one. An entry is taken on a rising edge only while `in_ready` is high. `in_ready` depends only on internal state and never on the valid inputs. A dispatcher that sees `in_ready` low must hold its instructions. The result input and the side-band output carry no back-pressure: each asserted `done_valid` cycle is consumed at once, and each `wb_valid` cycle is one register write that the register file must accept.

Top module: `completion_file`

## Requirements
- R1: After reset the log is empty, `comp_pc` is 0, `in_ready` is 1, `cf_full`, `wb_valid` and `recovered` are 0, and every shadow register holds 0.
- R2: On an edge where `in_ready` is 1 and `in0_valid` is 1, slot 0 is appended, followed by slot 1 if `in1_valid` is 1. Slot 1 with `in0_valid` low is ignored.
- R3: `cf_full` is 1 and `in_ready` is 0 while fewer than two entries of the DEPTH-entry log are free. Dispatch inputs offered while `in_ready` is 0 are ignored.
- R4: A result report updates the oldest entry that has not yet completed and whose station tag matches. Its data and fault flag are stored. A report that matches no such entry is ignored.
- R5: Retirement happens on the edge after the completing report is captured. It is in program order: the oldest entry retires once it has completed, and the next entry retires in the same cycle if it has also completed without a fault. `comp_pc` then shows the PC of the youngest entry retired.
- R6: Each retiring entry writes its result into the shadow register indexed by its destination field. When two retiring entries in one cycle name the same register, the younger one's result remains.
- R7: When the oldest entry has completed with a fault and its memory flag is 0 (arithmetic), it retires: its result is written to the shadow registers and `comp_pc` becomes its PC. Normal operation then stops.
- R8: When the oldest entry has completed with a fault and its memory flag is 1, it does not retire. The shadow registers and `comp_pc` stay as they were, and normal operation stops.
- R9: A fault on a younger entry does not stop older entries from retiring. Recovery starts only at the oldest faulting entry in program order.
- R10: From the cycle after the fault is taken, `wb_valid` is 1 for exactly NREG cycles, with `wb_reg` stepping 0,1,...,NREG-1 and `wb_data` the matching shadow value. `recovered` then rises and stays at 1, `in_ready` stays 0, and `comp_pc` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_valid | input | 1 | Slot 0 (older) instruction offered |
| in0_tag | input | TAG_W | Slot 0 reservation station tag |
| in0_dst | input | $clog2(NREG) | Slot 0 destination register |
| in0_mem | input | 1 | Slot 0 is a memory operation |
| in0_pc | input | PC_W | Slot 0 program counter |
| in1_valid | input | 1 | Slot 1 (younger) instruction offered |
| in1_tag | input | TAG_W | Slot 1 reservation station tag |
| in1_dst | input | $clog2(NREG) | Slot 1 destination register |
| in1_mem | input | 1 | Slot 1 is a memory operation |
| in1_pc | input | PC_W | Slot 1 program counter |
| in_ready | output | 1 | Dispatch slots are accepted this cycle |
| cf_full | output | 1 | Fewer than two free entries |
| done_valid | input | 1 | Result report present |
| done_tag | input | TAG_W | Station tag of the report |
| done_data | input | DATA_W | Result value |
| done_exc | input | 1 | Result carries a fault |
| comp_pc | output | PC_W | PC of the youngest retired entry |
| wb_valid | output | 1 | Side-band register restore write |
| wb_reg | output | $clog2(NREG) | Register index of the restore write |
| wb_data | output | DATA_W | Restore data |
| recovered | output | 1 | Restore finished, state is clean |

## Verification
Two functions can fall on the same edge. The first case is a pair retiring into the same shadow register: the younger result of the pair is reported before the older one, so both are complete when the head is examined, and the later restore stream shows which value survived. The second case is a completion that lands on a younger entry while the head is still pending, including a younger fault. The bench checks that `comp_pc` does not move early and that no restore starts until the older entry resolves. A scoreboard queue holds the expected restore writes, and the monitor compares each `wb_valid` beat against that queue.

// File: rtl/cfile_pkg.sv
package cfile_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_RESTORE = 2'd1,
    MODE_CLEAN   = 2'd2
  } cf_mode_e;

endpackage

// File: rtl/cf_match.sv
// Finds the oldest pending entry whose station tag equals the reported tag.
module cf_match #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            pend_vec,
  input  logic [DEPTH-1:0][TAG_W-1:0] tag_arr,
  input  logic [PTR_W-1:0]            head,
  input  logic                        req_valid,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        hit,
  output logic [PTR_W-1:0]            hit_idx
);

  logic [PTR_W-1:0] scan_idx;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    scan_idx = head;
    for (int k = 0; k < DEPTH; k++) begin
      scan_idx = head + PTR_W'(k);
      if (!hit && req_valid && pend_vec[scan_idx] && tag_arr[scan_idx] == req_tag) begin
        hit     = 1'b1;
        hit_idx = scan_idx;
      end
    end
  end

endmodule

// File: rtl/cf_retire_sel.sv
// Decides how many head entries leave this cycle and whether a fault stops the log.
module cf_retire_sel (
  input  logic run,
  input  logic h_valid,
  input  logic h_done,
  input  logic h_exc,
  input  logic h_mem,
  input  logic n_valid,
  input  logic n_done,
  input  logic n_exc,
  output logic ret0,
  output logic ret1,
  output logic stop
);

  logic h_ready;

  always_comb begin
    h_ready = run && h_valid && h_done;
    ret0    = h_ready && !(h_exc && h_mem);
    stop    = h_ready && h_exc;
    ret1    = ret0 && !h_exc && n_valid && n_done && !n_exc;
  end

endmodule

// File: rtl/cf_shadow.sv
// Shadow copy of the architectural registers, two write ports, one read port.
module cf_shadow #(
  parameter int NREG   = 4,
  parameter int DATA_W = 32,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we0,
  input  logic [RIDX_W-1:0] wa0,
  input  logic [DATA_W-1:0] wd0,
  input  logic              we1,
  input  logic [RIDX_W-1:0] wa1,
  input  logic [DATA_W-1:0] wd1,
  input  logic [RIDX_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);

  logic [NREG-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (we1 && wa1 == RIDX_W'(g)) begin
        regs_q[g] <= wd1;   // younger of the pair wins
      end else if (we0 && wa0 == RIDX_W'(g)) begin
        regs_q[g] <= wd0;
      end
    end
  end

  assign rd = regs_q[ra];

  // R6
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && we1 && wa0 == wa1) |=> regs_q[$past(wa1)] == $past(wd1));

endmodule

// File: rtl/completion_file.sv
module completion_file
  import cfile_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int PC_W   = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in0_valid,
  input  logic [TAG_W-1:0]  in0_tag,
  input  logic [RIDX_W-1:0] in0_dst,
  input  logic              in0_mem,
  input  logic [PC_W-1:0]   in0_pc,
  input  logic              in1_valid,
  input  logic [TAG_W-1:0]  in1_tag,
  input  logic [RIDX_W-1:0] in1_dst,
  input  logic              in1_mem,
  input  logic [PC_W-1:0]   in1_pc,
  output logic              in_ready,
  output logic              cf_full,
  input  logic              done_valid,
  input  logic [TAG_W-1:0]  done_tag,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_exc,
  output logic [PC_W-1:0]   comp_pc,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data,
  output logic              recovered
);

  localparam logic [CNT_W-1:0] FREE_LIMIT = CNT_W'(DEPTH - 2);

  logic [DEPTH-1:0]              ent_valid_q, ent_done_q, ent_exc_q, ent_mem_q;
  logic [DEPTH-1:0][TAG_W-1:0]   ent_tag_q;
  logic [DEPTH-1:0][RIDX_W-1:0]  ent_dst_q;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_data_q;
  logic [DEPTH-1:0][PC_W-1:0]    ent_pc_q;

  logic [PTR_W-1:0]  head_q, tail_q, head1, tail1;
  logic [CNT_W-1:0]  count_q;
  logic [RIDX_W-1:0] rix_q;
  logic [PC_W-1:0]   comp_pc_q;
  cf_mode_e          mode_q;

  logic run, take0, take1, match_hit, ret0, ret1, stop;
  logic [PTR_W-1:0] match_idx;

  assign run      = (mode_q == MODE_RUN);
  assign cf_full  = (count_q > FREE_LIMIT);
  assign in_ready = run && !cf_full;
  assign take0    = in0_valid && in_ready;
  assign take1    = take0 && in1_valid;
  assign head1    = head_q + PTR_W'(1);
  assign tail1    = tail_q + PTR_W'(1);

  cf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .pend_vec (ent_valid_q & ~ent_done_q),
    .tag_arr  (ent_tag_q),
    .head     (head_q),
    .req_valid(done_valid && run),
    .req_tag  (done_tag),
    .hit      (match_hit),
    .hit_idx  (match_idx)
  );

  cf_retire_sel u_sel (
    .run    (run),
    .h_valid(ent_valid_q[head_q]),
    .h_done (ent_done_q[head_q]),
    .h_exc  (ent_exc_q[head_q]),
    .h_mem  (ent_mem_q[head_q]),
    .n_valid(ent_valid_q[head1]),
    .n_done (ent_done_q[head1]),
    .n_exc  (ent_exc_q[head1]),
    .ret0   (ret0),
    .ret1   (ret1),
    .stop   (stop)
  );

  cf_shadow #(.NREG(NREG), .DATA_W(DATA_W)) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .we0  (ret0),
    .wa0  (ent_dst_q[head_q]),
    .wd0  (ent_data_q[head_q]),
    .we1  (ret1),
    .wa1  (ent_dst_q[head1]),
    .wd1  (ent_data_q[head1]),
    .ra   (rix_q),
    .rd   (wb_data)
  );

  // Entry storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid_q <= '0;
      ent_done_q  <= '0;
      ent_exc_q   <= '0;
      ent_mem_q   <= '0;
      ent_tag_q   <= '0;
      ent_dst_q   <= '0;
      ent_data_q  <= '0;
      ent_pc_q    <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (take0 && tail_q == PTR_W'(i)) begin
          ent_valid_q[i] <= 1'b1;
          ent_done_q[i]  <= 1'b0;
          ent_exc_q[i]   <= 1'b0;
          ent_mem_q[i]   <= in0_mem;
          ent_tag_q[i]   <= in0_tag;
          ent_dst_q[i]   <= in0_dst;
          ent_pc_q[i]    <= in0_pc;
        end else if (take1 && tail1 == PTR_W'(i)) begin
          ent_valid_q[i] <= 1'b1;
          ent_done_q[i]  <= 1'b0;
          ent_exc_q[i]   <= 1'b0;
          ent_mem_q[i]   <= in1_mem;
          ent_tag_q[i]   <= in1_tag;
          ent_dst_q[i]   <= in1_dst;
          ent_pc_q[i]    <= in1_pc;
        end
        if (match_hit && match_idx == PTR_W'(i)) begin
          ent_done_q[i] <= 1'b1;
          ent_exc_q[i]  <= done_exc;
          ent_data_q[i] <= done_data;
        end
        if ((ret0 && head_q == PTR_W'(i)) || (ret1 && head1 == PTR_W'(i))) begin
          ent_valid_q[i] <= 1'b0;
        end
      end
    end
  end

  // Pointers, published PC and recovery sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      count_q   <= '0;
      comp_pc_q <= '0;
      mode_q    <= MODE_RUN;
      rix_q     <= '0;
    end else begin
      tail_q  <= tail_q + PTR_W'(take0) + PTR_W'(take1);
      head_q  <= head_q + PTR_W'(ret0) + PTR_W'(ret1);
      count_q <= count_q + CNT_W'(take0) + CNT_W'(take1) - CNT_W'(ret0) - CNT_W'(ret1);
      if (ret1) begin
        comp_pc_q <= ent_pc_q[head1];
      end else if (ret0) begin
        comp_pc_q <= ent_pc_q[head_q];
      end
      unique case (mode_q)
        MODE_RUN: if (stop) begin
          mode_q <= MODE_RESTORE;
          rix_q  <= '0;
        end
        MODE_RESTORE: begin
          rix_q <= rix_q + RIDX_W'(1);
          if (rix_q == RIDX_W'(NREG - 1)) mode_q <= MODE_CLEAN;
        end
        default: mode_q <= MODE_CLEAN;
      endcase
    end
  end

  assign comp_pc   = comp_pc_q;
  assign wb_valid  = (mode_q == MODE_RESTORE);
  assign wb_reg    = rix_q;
  assign recovered = (mode_q == MODE_CLEAN);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R3
  full_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cf_full |=> count_q <= $past(count_q));

  // R4
  match_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> ent_done_q[$past(match_idx)]);

  // R5
  empty_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |=> $stable(comp_pc));

  // R10
  pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(comp_pc));

  // R10
  clean_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovered |=> recovered);

  // R10
  restore_then_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_valid) |-> recovered);

endmodule

// File: tb/completion_file_tb_top.sv
module completion_file_tb_top;

  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in0_valid = 0, in1_valid = 0, in0_mem = 0, in1_mem = 0;
  logic [3:0]  in0_tag = 0, in1_tag = 0;
  logic [1:0]  in0_dst = 0, in1_dst = 0;
  logic [7:0]  in0_pc = 0, in1_pc = 0;
  logic        done_valid = 0, done_exc = 0;
  logic [3:0]  done_tag = 0;
  logic [31:0] done_data = 0;
  logic        in_ready, cf_full, wb_valid, recovered;
  logic [7:0]  comp_pc;
  logic [1:0]  wb_reg;
  logic [31:0] wb_data;

  int tests = 0;
  int fails = 0;
  logic [1:0]  exp_reg[$];
  logic [31:0] exp_dat[$];

  always #2 clk = ~clk;

  completion_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_tag(in0_tag), .in0_dst(in0_dst), .in0_mem(in0_mem), .in0_pc(in0_pc),
    .in1_valid(in1_valid), .in1_tag(in1_tag), .in1_dst(in1_dst), .in1_mem(in1_mem), .in1_pc(in1_pc),
    .in_ready(in_ready), .cf_full(cf_full),
    .done_valid(done_valid), .done_tag(done_tag), .done_data(done_data), .done_exc(done_exc),
    .comp_pc(comp_pc), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .recovered(recovered)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected restore writes
  task automatic expect_wb(input logic [1:0] r, input logic [31:0] d);
    exp_reg.push_back(r);
    exp_dat.push_back(d);
  endtask

  // Monitor side: every restore beat is popped and compared (R10, R6)
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (exp_reg.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10 unexpected restore actual=%0h expected=none", wb_reg);
      end else begin
        check("R10 restore index", {30'd0, wb_reg}, {30'd0, exp_reg.pop_front()});
        check("R6 restore data", wb_data, exp_dat.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic v0, input logic [3:0] t0, input logic [1:0] d0, input logic m0,
                     input logic [7:0] p0, input logic v1, input logic [3:0] t1,
                     input logic [1:0] d1, input logic m1, input logic [7:0] p1);
    in0_valid = v0; in0_tag = t0; in0_dst = d0; in0_mem = m0; in0_pc = p0;
    in1_valid = v1; in1_tag = t1; in1_dst = d1; in1_mem = m1; in1_pc = p1;
    @(negedge clk);
    in0_valid = 0; in1_valid = 0;
  endtask

  task automatic fin(input logic [3:0] t, input logic [31:0] d, input logic e);
    done_valid = 1; done_tag = t; done_data = d; done_exc = e;
    @(negedge clk);
    done_valid = 0; done_exc = 0;
  endtask

  task automatic finish_restore();
    repeat (NREG) @(negedge clk);
    check("R10 recovered", {31'd0, recovered}, 32'd1);
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    check("R10 all beats seen", exp_reg.size(), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 comp_pc", {24'd0, comp_pc}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 cf_full", {31'd0, cf_full}, 32'd0);
    check("R1 wb_valid", {31'd0, wb_valid}, 32'd0);
    check("R1 recovered", {31'd0, recovered}, 32'd0);

    // Pair retire and memory fault
    put(1, 4'd8, 2'd1, 0, 8'd1, 1, 4'd9, 2'd2, 0, 8'd2);
    fin(4'd9, 32'h22, 0);
    @(negedge clk);
    check("R5 younger done alone", {24'd0, comp_pc}, 32'd0);
    fin(4'd8, 32'h11, 0);
    check("R5 not before edge", {24'd0, comp_pc}, 32'd0);
    @(negedge clk);
    check("R5 two retire", {24'd0, comp_pc}, 32'd2);
    expect_wb(2'd0, 32'h0);   // R1 shadow reset value
    expect_wb(2'd1, 32'h11);
    expect_wb(2'd2, 32'h22);
    expect_wb(2'd3, 32'h0);
    put(1, 4'd12, 2'd3, 1, 8'd3, 0, 0, 0, 0, 0);
    fin(4'd12, 32'h55, 1);
    @(negedge clk);
    check("R8 pc held", {24'd0, comp_pc}, 32'd2);
    finish_restore();

    // Oldest match, unmatched report, same-register pair, arithmetic fault
    do_reset();
    put(1, 4'd8, 2'd0, 0, 8'd1, 1, 4'd8, 2'd1, 0, 8'd2);
    fin(4'd8, 32'hA0, 0);
    @(negedge clk);
    check("R4 oldest updated", {24'd0, comp_pc}, 32'd1);
    fin(4'd5, 32'hBAD, 0);
    @(negedge clk);
    check("R4 unmatched ignored", {24'd0, comp_pc}, 32'd1);
    fin(4'd8, 32'hB0, 0);
    @(negedge clk);
    check("R4 second match", {24'd0, comp_pc}, 32'd2);
    put(1, 4'd10, 2'd3, 0, 8'd3, 1, 4'd11, 2'd3, 0, 8'd4);
    fin(4'd11, 32'hD0, 0);
    fin(4'd10, 32'hC0, 0);
    @(negedge clk);
    check("R6 pair retired", {24'd0, comp_pc}, 32'd4);
    expect_wb(2'd0, 32'hA0);
    expect_wb(2'd1, 32'hB0);
    expect_wb(2'd2, 32'hE0);
    expect_wb(2'd3, 32'hD0);   // R6 younger of pair
    put(1, 4'd9, 2'd2, 0, 8'd5, 0, 0, 0, 0, 0);
    fin(4'd9, 32'hE0, 1);
    @(negedge clk);
    check("R7 fault pc", {24'd0, comp_pc}, 32'd5);
    finish_restore();

    // Younger fault first, then older fault
    do_reset();
    put(1, 4'd8, 2'd0, 0, 8'd1, 1, 4'd9, 2'd1, 0, 8'd2);
    fin(4'd9, 32'h99, 1);
    @(negedge clk);
    check("R9 no early stop", {31'd0, in_ready}, 32'd1);
    check("R9 no early restore", {31'd0, wb_valid}, 32'd0);
    expect_wb(2'd0, 32'h77);
    expect_wb(2'd1, 32'h0);
    expect_wb(2'd2, 32'h0);
    expect_wb(2'd3, 32'h0);
    fin(4'd8, 32'h77, 1);
    @(negedge clk);
    check("R9 older fault pc", {24'd0, comp_pc}, 32'd1);
    finish_restore();

    // Back-pressure, ignored slots, pointer wrap
    do_reset();
    for (int i = 1; i <= 3; i++)
      put(1, 4'(2*i-1), 2'(2*i-1), 0, 8'(2*i-1), 1, 4'(2*i), 2'(2*i), 0, 8'(2*i));
    check("R3 ready at two free", {31'd0, in_ready}, 32'd1);
    check("R3 not full", {31'd0, cf_full}, 32'd0);
    put(1, 4'd7, 2'd3, 0, 8'd7, 0, 0, 0, 0, 0);
    check("R3 ready low", {31'd0, in_ready}, 32'd0);
    check("R3 full", {31'd0, cf_full}, 32'd1);
    put(1, 4'd15, 2'd0, 0, 8'd99, 1, 4'd14, 2'd0, 0, 8'd98);
    for (int i = 1; i <= 7; i++) fin(4'(i), 32'(i * 16), 0);
    @(negedge clk);
    check("R5 one per cycle", {24'd0, comp_pc}, 32'd7);
    check("R3 ready again", {31'd0, in_ready}, 32'd1);
    put(0, 0, 0, 0, 0, 1, 4'd13, 2'd0, 0, 8'd97);
    fin(4'd15, 32'hFF, 1);
    fin(4'd14, 32'hFF, 1);
    fin(4'd13, 32'hFF, 1);
    @(negedge clk);
    check("R3 full offers dropped", {31'd0, wb_valid}, 32'd0);
    check("R2 lone slot1 dropped", {24'd0, comp_pc}, 32'd7);
    put(1, 4'd8, 2'd0, 0, 8'd8, 1, 4'd9, 2'd1, 0, 8'd9);
    fin(4'd9, 32'h90, 0);
    fin(4'd8, 32'h80, 0);
    @(negedge clk);
    check("R2 order after wrap", {24'd0, comp_pc}, 32'd9);
    expect_wb(2'd0, 32'h80);
    expect_wb(2'd1, 32'h90);
    expect_wb(2'd2, 32'h60);
    expect_wb(2'd3, 32'h70);
    put(1, 4'd10, 2'd2, 1, 8'd10, 0, 0, 0, 0, 0);
    fin(4'd10, 32'h1, 1);
    @(negedge clk);
    check("R8 pc held", {24'd0, comp_pc}, 32'd9);
    finish_restore();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule